// File: doc/BRIEF.md
# Burst Register Read Port for a Multiplexed Address/Data Host Bus

This block is the slave side of a multiplexed-address host bus that reads an internal byte-wide register file in bursts. The host selects the block with an active-low chip select. It pulses an address-latch strobe high with an 11-bit start address, and then issues a series of active-low read strobes. The block does not take a new address for each strobe. The first strobe reads the start address, and each strobe that completes moves the read pointer on by one location. A new latch pulse starts a fresh burst.

All bus pins are asynchronous to the block's clock, so each one passes through a two-stage synchronizer before any edge is detected. Every accepted read strobe pulls the ready output low for `READY_LAT` clock cycles, which models the register access time, and then releases it. The block enables the data-bus drivers for as long as the read is in progress. While the drivers are enabled it presents the register file's byte; otherwise the data output is zero. A three-state machine sequences each read. `RD_IDLE` goes to `RD_WAIT` on a qualified strobe fall. `RD_WAIT` goes to `RD_VALID` after the latency count, and goes back to `RD_IDLE` on an early strobe release or on loss of chip select. `RD_VALID` goes back to `RD_IDLE` on strobe release or on loss of chip select.

Top module: `burst_read_port`

## Requirements
- R1: After reset, ready is 1, data-bus enable is 0, data output is 0 and the register address output is 0.
- R2: While the synchronized latch strobe is high and chip select is active, the register address output follows the synchronized address pins. When the latch strobe falls, the address seen in the last cycle it was high becomes the burst base and the offset becomes 0.
- R3: While chip select (active low) is high, latch pulses and read strobes are ignored: the base and offset stay the same, ready stays 1 and the data-bus enable stays 0.
- R4: A read-strobe fall with chip select active drives ready low from the third clock edge after the pin falls, for exactly `READY_LAT` cycles (default 2). Ready then returns to 1.
- R5: The data-bus enable is 1 from the edge where ready falls until the strobe release has passed the synchronizer. While it is 1 the data output equals the register file byte; otherwise the data output is 0.
- R6: Outside the latch strobe, the register address output is base plus offset modulo 2048. The first read of a burst reads the base, and each completed strobe with chip select active adds one (0x7FF is followed by 0x000).
- R7: A new latch pulse during a burst sets the offset back to 0, so the next read returns the new base.
- R8: If the strobe is released before ready rises, the read ends at once: ready goes to 1, the enable goes to 0, and the offset still advances by one.
- R9: If chip select is deasserted during a read, the read is aborted to idle and the offset does not advance, even when the strobe is later released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_ale | input | 1 | Address-latch strobe, active high, asynchronous |
| bus_addr | input | 11 | Start address pins, asynchronous |
| bus_rd_n | input | 1 | Read strobe, active low, asynchronous |
| rf_addr_o | output | 11 | Address presented to the register file |
| rf_data_i | input | 8 | Byte returned by the register file for `rf_addr_o` |
| bus_data_o | output | 8 | Read data toward the bidirectional bus pins |
| bus_data_oe_o | output | 1 | Tri-state enable for the data-bus drivers |
| bus_ready_o | output | 1 | Ready handshake, low while read data is not yet valid |

## Verification
The bench runs several bursts. One crosses the top of the 11-bit address space: a design that does not wrap the offset would read past 0x7FF instead of returning to 0x000. Another burst is relatched in its middle, and a design that keeps the old offset would return base+n rather than the new base. Single-cycle strobes released during the wait window check that the pointer still advances. A strobe pending while chip select is dropped must not advance it, or the following read would be off by one. Latch pulses and strobes given with chip select inactive must leave both the enable and the pointer unchanged, which the next read then shows. The ready-low window is measured on every read, so a counter off by one shows up as the wrong number of low cycles.

// File: rtl/brp_pkg.sv
package brp_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_WAIT  = 2'd1,
        RD_VALID = 2'd2
    } rd_state_t;

endpackage

// File: rtl/brp_sync.sv
module brp_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/brp_addr_gen.sv
module brp_addr_gen #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              step_i,
    input  logic              pass_i,
    input  logic [ADDR_W-1:0] pass_addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] offset_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            offset_q <= '0;
        end else if (latch_i) begin
            base_q   <= start_addr_i;
            offset_q <= '0;
        end else if (step_i) begin
            offset_q <= offset_q + 1'b1;
        end
    end

    always_comb begin
        if (pass_i) addr_o = pass_addr_i;
        else        addr_o = base_q + offset_q;
    end

    assert_offset_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (offset_q == '0));

    assert_offset_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !latch_i) |=> (offset_q == $past(offset_q) + 1'b1));

    assert_offset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !latch_i) |=> $stable(offset_q));

endmodule

// File: rtl/brp_rd_fsm.sv
module brp_rd_fsm
    import brp_pkg::*;
#(
    parameter int READY_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act_i,
    input  logic rd_fall_i,
    input  logic rd_rise_i,
    output logic ready_o,
    output logic drive_o,
    output logic step_o
);

    localparam int CNT_W = (READY_LAT > 1) ? $clog2(READY_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_LAT - 1);

    rd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (cs_act_i && rd_fall_i) state_d = RD_WAIT;
            RD_WAIT: begin
                if (!cs_act_i || rd_rise_i) state_d = RD_IDLE;
                else if (cnt_q == CNT_LAST) state_d = RD_VALID;
            end
            RD_VALID: if (!cs_act_i || rd_rise_i) state_d = RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RD_WAIT && state_d == RD_WAIT) cnt_q <= cnt_q + 1'b1;
            else                                          cnt_q <= '0;
        end
    end

    always_comb begin
        ready_o = (state_q != RD_WAIT);
        drive_o = (state_q != RD_IDLE);
        step_o  = cs_act_i && rd_rise_i && (state_q != RD_IDLE);
    end

    assert_ready_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(cs_act_i && rd_fall_i));

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> (state_q == RD_IDLE));

    assert_drive_while_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> drive_o);

    assert_early_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_WAIT && rd_rise_i) |=> (ready_o && !drive_o));

endmodule

// File: rtl/burst_read_port.sv
module burst_read_port #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int READY_LAT = 2,
    parameter int SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_ale,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_n,
    output logic [ADDR_W-1:0] rf_addr_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe_o,
    output logic              bus_ready_o
);

    localparam logic [2:0] CTL_IDLE = 3'b101;

    logic [2:0]        ctl_s;
    logic [ADDR_W-1:0] addr_s, addr_q;
    logic              ale_q, rd_act_q;
    logic              cs_act, ale_s, rd_act;
    logic              ale_fall, rd_fall, rd_rise, latch, step, drive;

    brp_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_cs_n, bus_ale, bus_rd_n}),
        .q_o   (ctl_s)
    );

    brp_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_N), .RST_VAL('0)) u_addr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_addr),
        .q_o   (addr_s)
    );

    assign cs_act = ~ctl_s[2];
    assign ale_s  = ctl_s[1];
    assign rd_act = ~ctl_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q    <= 1'b0;
            rd_act_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            ale_q    <= ale_s;
            rd_act_q <= rd_act;
            addr_q   <= addr_s;
        end
    end

    assign ale_fall = ale_q & ~ale_s;
    assign rd_fall  = rd_act & ~rd_act_q;
    assign rd_rise  = ~rd_act & rd_act_q;
    assign latch    = ale_fall & cs_act;

    brp_addr_gen #(.ADDR_W(ADDR_W)) u_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_i      (latch),
        .start_addr_i (addr_q),
        .step_i       (step),
        .pass_i       (ale_s & cs_act),
        .pass_addr_i  (addr_s),
        .addr_o       (rf_addr_o)
    );

    brp_rd_fsm #(.READY_LAT(READY_LAT)) u_rd_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act_i  (cs_act),
        .rd_fall_i (rd_fall),
        .rd_rise_i (rd_rise),
        .ready_o   (bus_ready_o),
        .drive_o   (drive),
        .step_o    (step)
    );

    assign bus_data_oe_o = drive;
    assign bus_data_o    = drive ? rf_data_i : '0;

    assert_no_drive_without_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !bus_data_oe_o);

    assert_latch_only_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> $past(ale_s));

endmodule

// File: tb/test_burst_read_port.sv
module test_burst_read_port;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1;
    logic [10:0] addr = '0;
    logic [10:0] rf_addr;
    logic [7:0]  rf_data, dout;
    logic        oe, ready;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rf_val(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'h15};
    endfunction

    assign rf_data = rf_val(rf_addr);

    burst_read_port #(.READY_LAT(LAT)) i_burst_read_port (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_ale(ale), .bus_addr(addr),
        .bus_rd_n(rd_n), .rf_addr_o(rf_addr), .rf_data_i(rf_data),
        .bus_data_o(dout), .bus_data_oe_o(oe), .bus_ready_o(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { logic cs_n; logic ale; logic rd_n; logic [10:0] addr; } pin_t;
    pin_t hist[$];
    int   m_st = 0, m_left = 0;
    int   m_base = 0, m_off = 0;
    int   e_addr = 0;
    bit   m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < 4; i++) hist.push_back('{1'b1, 1'b0, 1'b1, 11'h0});
            m_st = 0; m_left = 0; m_base = 0; m_off = 0; e_addr = 0; m_live = 0;
        end else begin
            pin_t c, o;
            bit cs, rdf, rdr, lat;
            hist.push_front('{cs_n, ale, rd_n, addr});
            void'(hist.pop_back());
            c = hist[2]; o = hist[3];
            cs  = !c.cs_n;
            lat = cs && o.ale && !c.ale;
            rdf = !c.rd_n && o.rd_n;
            rdr = c.rd_n && !o.rd_n;
            if (lat) begin
                m_base = o.addr; m_off = 0;
            end else if (cs && rdr && m_st != 0) begin
                m_off = (m_off + 1) % 2048;
            end
            case (m_st)
                0: if (cs && rdf) begin m_st = 1; m_left = LAT - 1; end
                1: if (!cs || rdr) m_st = 0;
                   else if (m_left == 0) m_st = 2;
                   else m_left--;
                default: if (!cs || rdr) m_st = 0;
            endcase
            if (hist[1].ale && !hist[1].cs_n) e_addr = hist[1].addr;
            else                              e_addr = (m_base + m_off) % 2048;
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live) begin
            chk(ready === (m_st != 1), "R4 ready", ready, m_st != 1);
            chk(oe === (m_st != 0), "R5 enable", oe, m_st != 0);
            chk(rf_addr === 11'(e_addr), "R6 address", rf_addr, e_addr);
            chk(dout === ((m_st != 0) ? rf_val(11'(e_addr)) : 8'h0), "R5 data", dout,
                (m_st != 0) ? rf_val(11'(e_addr)) : 8'h0);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic latch_addr(input logic [10:0] a);
        @(negedge clk); ale = 1'b1; addr = a;
        repeat (4) @(negedge clk);
        if (!cs_n) chk(rf_addr === a, "R2 pass-through", rf_addr, a);
        ale = 1'b0;
        repeat (2) @(negedge clk);
        addr = ~a;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_one(input logic [10:0] exp_a, input string req);
        int low = 0;
        bit seen = 0;
        logic [7:0] got = '0;
        @(negedge clk); rd_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!ready) begin seen = 1; low++; end
            else if (seen) begin got = dout; break; end
        end
        chk(low == LAT, "R4 latency", low, LAT);
        chk(got === rf_val(exp_a), req, got, rf_val(exp_a));
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && oe === 1'b0, "R1 ready/enable", {ready, oe}, 2'b10);
        chk(dout === 8'h0 && rf_addr === 11'h0, "R1 data/address", dout, 0);
        rst_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        repeat (3) @(negedge clk);

        // basic burst (R6)
        latch_addr(11'h123);
        read_one(11'h123, "R6 first read");
        read_one(11'h124, "R6 second read");
        read_one(11'h125, "R6 third read");

        // wrap at top of space (R6)
        latch_addr(11'h7FF);
        read_one(11'h7FF, "R6 top");
        read_one(11'h000, "R6 wrap");

        // relatch mid-burst (R7)
        latch_addr(11'h040);
        read_one(11'h040, "R7 before relatch");
        latch_addr(11'h200);
        read_one(11'h200, "R7 after relatch");

        // early release during wait (R8)
        latch_addr(11'h300);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ready === 1'b1 && oe === 1'b0, "R8 back to idle", {ready, oe}, 2'b10);
        read_one(11'h301, "R8 offset advanced");

        // chip select abort (R9)
        latch_addr(11'h500);
        @(negedge clk); rd_n = 1'b0;
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(oe === 1'b0, "R9 abort enable", oe, 0);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        read_one(11'h500, "R9 no advance");

        // ignored while deselected (R3)
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        latch_addr(11'h600);
        @(negedge clk); rd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(oe === 1'b0 && ready === 1'b1, "R3 strobe ignored", {ready, oe}, 2'b10);
        end
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        read_one(11'h501, "R3 latch ignored");

        repeat (5) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule